// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Model

This block is a cycle-accurate, synthesizable model of a small pipelined synchronous burst SRAM. It has separate data-in and data-out buses, and a data-valid flag takes the place of a three-state data bus. Every control input is captured on the rising clock edge, except the output enable, which gates the output as a combinational input.

A new access starts when one of two address strobes is seen. The processor strobe takes priority over the controller strobe, but the processor strobe is only accepted while the first enable is asserted. The three enables are looked at only on the edge that loads an address. After the load, a burst runs inside an aligned block of four words: each edge that sees the step input low moves to the next word, and the offset wraps within the block. On each access the write controls decide between a write and a read. A read returns its word one cycle after the edge that captured its address.

Top module: `burst_sram_model`

## Requirements
- R1: After reset the model is deselected: `dvalid` is 0 and `dout` is 0 until a selected read has been loaded.
- R2: When both strobes are low on the same edge, the processor strobe is honoured. If the processor strobe cannot be accepted (because `en1_n` is high), the controller strobe is taken instead, and its enable check then deselects the model.
- R3: A low `pstb_n` is ignored while `en1_n` is high. A burst in progress carries on as if no strobe had been seen.
- R4: `en1_n` (active low), `en2` (active high) and `en3_n` (active low) are only evaluated on an edge that loads an address. Changing them during a burst has no effect.
- R5: A strobe taken while the enables do not all select the model deselects it. Afterwards no read data is valid, and write controls change no memory word, until a selected load occurs.
- R6: A low `wr_all_n` during an access writes all four byte lanes, whatever `lane_wen_n` and `lane_sel_n` are.
- R7: Otherwise, byte lane i (bits 8i+7..8i of the data) is written only when `lane_wen_n` is 0 and `lane_sel_n[i]` is 0. An access with no lane written is a read.
- R8: Read data and `dvalid`=1 appear after the first falling edge that follows the rising edge which captured the read address. Write cycles never raise `dvalid`.
- R9: While `oe_n` is high, `dvalid` is 0 and `dout` is 0. Lowering `oe_n` shows the pending read data in the same cycle.
- R10: The first read returned after a deselected state, including the state after reset, is masked: `dvalid` stays 0 for it even with `oe_n` low.
- R11: The burst offset is the low 2 address bits. An edge with `nxt_n` low and no load accesses offset+1 modulo 4 within the same block. An edge with `nxt_n` high accesses the same word again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | External word address, loaded on a strobe |
| pstb_n | input | 1 | Processor address strobe, active low, higher priority |
| cstb_n | input | 1 | Controller address strobe, active low |
| nxt_n | input | 1 | Burst step, active low |
| en1_n | input | 1 | Enable 1, active low; also gates the processor strobe |
| en2 | input | 1 | Enable 2, active high |
| en3_n | input | 1 | Enable 3, active low |
| wr_all_n | input | 1 | Write all lanes, active low |
| lane_wen_n | input | 1 | Byte-lane write enable, active low |
| lane_sel_n | input | LANES | Per-lane select, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not valid |
| dvalid | output | 1 | Read data on `dout` is valid |

## Verification
The hardest cases to reach are the ones where strobe priority, the enable check and the deselect mask all act at once. Examples are both strobes low while `en1_n` is high, and the masked first read that follows. The bench reaches them by first filling the whole array with computed patterns. It then runs scripted sequences: a selected burst, a double strobe that deselects the model, write attempts while deselected, and a reload whose first result must stay masked. Every word address is then a burst start, every one of the 16 lane-select patterns is written, and each result is compared with a model array kept in the bench.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_PROC = 2'd1,
    SRC_CTRL = 2'd2
  } strobe_src_e;
endpackage

// File: rtl/bsram_strobe_ctl.sv
module bsram_strobe_ctl
  import bsram_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pstb_n,
  input  logic cstb_n,
  input  logic en1_n,
  input  logic en2,
  input  logic en3_n,
  input  logic wr_req,
  output logic load,
  output logic sel_hit,
  output logic access,
  output logic rd_q,
  output logic first_rd_q
);
  strobe_src_e src;
  logic        active_q;

  always_comb begin
    if (!pstb_n && !en1_n)  src = SRC_PROC;
    else if (!cstb_n)       src = SRC_CTRL;
    else                    src = SRC_NONE;
    load    = (src != SRC_NONE);
    sel_hit = !en1_n && en2 && !en3_n;
    access  = load ? sel_hit : active_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= 1'b0;
      rd_q       <= 1'b0;
      first_rd_q <= 1'b0;
    end else begin
      if (load) active_q <= sel_hit;
      rd_q       <= access && !wr_req;
      first_rd_q <= load && sel_hit && !active_q && !wr_req;
    end
  end

  // R5
  desel_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !sel_hit) |=> !rd_q);

  // R4
  no_load_keeps_sel_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(active_q));

  // R3
  proc_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (!pstb_n && en1_n && cstb_n) |-> !load);
endmodule

// File: rtl/bsram_burst_gen.sv
module bsram_burst_gen #(
  parameter int ADDR_W  = 6,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              nxt_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] acc_addr
);
  localparam int HI_W = ADDR_W - BURST_W;

  logic [ADDR_W-1:0]  cur_q;
  logic [BURST_W-1:0] off_nxt;

  always_comb begin
    off_nxt  = cur_q[BURST_W-1:0] + {{(BURST_W-1){1'b0}}, !nxt_n};
    acc_addr = load ? addr_in : {cur_q[ADDR_W-1:BURST_W], off_nxt};
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= acc_addr;
  end

  // R11
  burst_block_fixed_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(cur_q[ADDR_W-1:ADDR_W-HI_W]));

  // R11
  hold_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (!load && nxt_n) |=> $stable(cur_q));
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                     clk,
  input  logic                     access,
  input  logic                     wr_all_n,
  input  logic                     lane_wen_n,
  input  logic [LANES-1:0]         lane_sel_n,
  input  logic [ADDR_W-1:0]        acc_addr,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  rd_data
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane_we
    assign lane_we[g] = access && (!wr_all_n || (!lane_wen_n && !lane_sel_n[g]));
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++) begin
      if (lane_we[i]) mem[acc_addr][i*LANE_W +: LANE_W] <= din[i*LANE_W +: LANE_W];
    end
    rd_data <= mem[acc_addr];
  end
endmodule

// File: rtl/burst_sram_model.sv
module burst_sram_model #(
  parameter int ADDR_W  = 6,
  parameter int LANES   = 4,
  parameter int LANE_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr,
  input  logic                     pstb_n,
  input  logic                     cstb_n,
  input  logic                     nxt_n,
  input  logic                     en1_n,
  input  logic                     en2,
  input  logic                     en3_n,
  input  logic                     wr_all_n,
  input  logic                     lane_wen_n,
  input  logic [LANES-1:0]         lane_sel_n,
  input  logic                     oe_n,
  input  logic [LANES*LANE_W-1:0]  din,
  output logic [LANES*LANE_W-1:0]  dout,
  output logic                     dvalid
);
  localparam int DATA_W = LANES * LANE_W;

  logic              load, sel_hit, access, rd_q, first_rd_q, wr_req;
  logic [ADDR_W-1:0] acc_addr;
  logic [DATA_W-1:0] rd_data;

  assign wr_req = !wr_all_n || (!lane_wen_n && !(&lane_sel_n));

  bsram_strobe_ctl u_ctl (
    .clk(clk), .rst(rst), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .en1_n(en1_n), .en2(en2), .en3_n(en3_n), .wr_req(wr_req),
    .load(load), .sel_hit(sel_hit), .access(access),
    .rd_q(rd_q), .first_rd_q(first_rd_q)
  );

  bsram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_burst (
    .clk(clk), .rst(rst), .load(load), .nxt_n(nxt_n),
    .addr_in(addr), .acc_addr(acc_addr)
  );

  bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .access(access), .wr_all_n(wr_all_n), .lane_wen_n(lane_wen_n),
    .lane_sel_n(lane_sel_n), .acc_addr(acc_addr), .din(din), .rd_data(rd_data)
  );

  always_comb begin
    dvalid = rd_q && !first_rd_q && !oe_n;
    dout   = dvalid ? rd_data : '0;
  end

  // R8
  valid_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    dvalid |-> $past(access));

  // R10
  first_read_masked_chk: assert property (@(posedge clk) disable iff (rst)
    first_rd_q |-> (dout == '0));
endmodule

// File: tb/burst_sram_model_tb_top.sv
`timescale 1ns/1ps
module burst_sram_model_tb_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic        clk = 1'b0;
  logic        rst;
  logic [AW-1:0] addr;
  logic        pstb_n, cstb_n, nxt_n, en1_n, en2, en3_n, wr_all_n, lane_wen_n, oe_n;
  logic [3:0]  lane_sel_n;
  logic [31:0] din, dout;
  logic        dvalid;

  logic [31:0] exp_mem [DEPTH];
  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_sram_model dut_i (
    .clk(clk), .rst(rst), .addr(addr), .pstb_n(pstb_n), .cstb_n(cstb_n),
    .nxt_n(nxt_n), .en1_n(en1_n), .en2(en2), .en3_n(en3_n),
    .wr_all_n(wr_all_n), .lane_wen_n(lane_wen_n), .lane_sel_n(lane_sel_n),
    .oe_n(oe_n), .din(din), .dout(dout), .dvalid(dvalid)
  );

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h0107_0B0D) ^ 32'hA5A5_5A5A;
  endfunction

  function automatic logic [5:0] burst_addr(input int a, input int k);
    return 6'((a & ~3) | ((a + k) & 3));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    pstb_n = 1; cstb_n = 1; nxt_n = 1; en1_n = 0; en2 = 1; en3_n = 0;
    wr_all_n = 1; lane_wen_n = 1; lane_sel_n = 4'hF; oe_n = 0; addr = '0; din = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd_ok(input string tag, input int a);
    chk({tag, " dvalid"}, 32'(dvalid), 32'd1);
    chk({tag, " data"}, dout, exp_mem[a]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    step();
    // R1 reset state
    chk("R1 dvalid after reset", 32'(dvalid), 32'd0);
    chk("R1 dout after reset", dout, 32'd0);

    // R6 fill every word with write-all bursts; lane controls set to noise
    for (int b = 0; b < DEPTH / 4; b++) begin
      for (int k = 0; k < 4; k++) begin
        idle();
        if (k == 0) begin cstb_n = 0; addr = AW'(b * 4); end
        else nxt_n = 0;
        wr_all_n = 0; lane_wen_n = b[0]; lane_sel_n = 4'(b);
        din = pat(b * 4 + k);
        exp_mem[b * 4 + k] = pat(b * 4 + k);
        step();
        if (b == 0 && k == 0) chk("R8 no valid on write", 32'(dvalid), 32'd0);
      end
    end

    // R8 R11 read bursts from every start address, linear wrap in block
    for (int a = 0; a < DEPTH; a++) begin
      for (int k = 0; k < 4; k++) begin
        idle();
        if (k == 0) begin pstb_n = 0; addr = AW'(a); end
        else nxt_n = 0;
        step();
        rd_ok("R8 R11 burst read", int'(burst_addr(a, k)));
      end
    end

    // R11 hold when step input high
    idle(); pstb_n = 0; addr = 6'd5; step(); rd_ok("R11 load", 5);
    idle(); step(); rd_ok("R11 hold", 5);
    idle(); nxt_n = 0; step(); rd_ok("R11 step", 6);
    idle(); nxt_n = 0; step(); rd_ok("R11 wrap pre", 7);
    idle(); nxt_n = 0; step(); rd_ok("R11 wrap", 4);

    // R7 all lane select patterns
    for (int p = 0; p < 16; p++) begin
      logic [31:0] nv;
      nv = ~pat(p + 100);
      idle(); cstb_n = 0; addr = 6'd9; lane_wen_n = 0; lane_sel_n = 4'(p); din = nv;
      for (int i = 0; i < 4; i++)
        if (!p[i]) exp_mem[9][i*8 +: 8] = nv[i*8 +: 8];
      step();
      idle(); pstb_n = 0; addr = 6'd9; step();
      rd_ok("R7 lane pattern", 9);
    end
    // R7 selects without lane enable: no write, behaves as a read
    idle(); cstb_n = 0; addr = 6'd9; lane_wen_n = 1; lane_sel_n = 4'h0; din = 32'hDEAD_BEEF;
    step(); rd_ok("R7 no enable read", 9);
    idle(); pstb_n = 0; addr = 6'd9; step(); rd_ok("R7 unchanged", 9);
    // R6 write-all overrides lane selects
    idle(); cstb_n = 0; addr = 6'd10; wr_all_n = 0; lane_wen_n = 0; lane_sel_n = 4'b0101;
    din = 32'h1234_5678; exp_mem[10] = 32'h1234_5678; step();
    idle(); pstb_n = 0; addr = 6'd10; step(); rd_ok("R6 all lanes", 10);

    // R3 processor strobe ignored while en1_n high
    idle(); pstb_n = 0; addr = 6'd16; step(); rd_ok("R3 load", 16);
    idle(); pstb_n = 0; en1_n = 1; addr = 6'd40; nxt_n = 0; step();
    rd_ok("R3 burst continues", 17);

    // R2 both strobes with en1_n high: controller strobe deselects
    idle(); pstb_n = 0; cstb_n = 0; en1_n = 1; addr = 6'd50; step();
    chk("R2 deselect dvalid", 32'(dvalid), 32'd0);
    // R2 both strobes with en1_n low: processor load, first read masked
    idle(); pstb_n = 0; cstb_n = 0; addr = 6'd33; step();
    chk("R10 masked after deselect", 32'(dvalid), 32'd0);
    chk("R10 masked dout", dout, 32'd0);
    idle(); nxt_n = 0; step(); rd_ok("R2 proc load burst", 34);

    // R4 enables ignored without a load
    idle(); en2 = 0; en3_n = 1; nxt_n = 0; step(); rd_ok("R4 enables ignored", 35);

    // R9 output enable gate
    idle(); oe_n = 1; step();
    chk("R9 oe high dvalid", 32'(dvalid), 32'd0);
    chk("R9 oe high dout", dout, 32'd0);
    oe_n = 0; #1;
    rd_ok("R9 oe low same cycle", 35);

    // R5 failed enable check deselects; writes then change nothing
    idle(); cstb_n = 0; en2 = 0; addr = 6'd20; step();
    chk("R5 deselect dvalid", 32'(dvalid), 32'd0);
    for (int k = 0; k < 3; k++) begin
      idle(); nxt_n = 0; wr_all_n = 0; din = 32'hBAD0_0000 + 32'(k); step();
      chk("R5 deselected no valid", 32'(dvalid), 32'd0);
    end
    idle(); pstb_n = 0; addr = 6'd20; step();
    chk("R10 masked after R5", 32'(dvalid), 32'd0);
    for (int k = 1; k < 4; k++) begin
      idle(); nxt_n = 0; step(); rd_ok("R5 memory unchanged", 20 + k);
    end
    idle(); pstb_n = 0; addr = 6'd20; step(); rd_ok("R5 word 20 unchanged", 20);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule